// File: doc/BRIEF.md
# Multi-dimensional element index remapper

This block turns the plain element number of a vector loop (0 up to VL-1) into a remapped element index, so that an operand can be walked as a 1D, 2D or 3D array in any of six loop-nesting orders. A single 32-bit shape word configures it. The word gives three dimension sizes, a permutation code that picks which dimension moves fastest, a small offset that is added in, and a modulus that wraps the final index.

The word and the vector length are captured on `start`. On the same edge a resume element number is loaded, and the three nested counters are rebuilt to match it. This lets a loop that was interrupted continue from the element where it stopped. Each `step` pulse, while `valid` is high, moves to the next element in one cycle. When the element number reaches VL, the counters freeze and `valid` drops.

Top module: `elem_remap`

## Requirements
- R1: The shape word holds the x size in bits 5..0, the y size in bits 11..6 and the z size in bits 17..12. Each size is biased by one, so a field value n gives n+1 positions in that dimension.
- R2: The permutation code in bits 24..22 sets which dimension moves fastest, then middle, then slowest: 0 gives x,y,z; 1 gives x,z,y; 2 gives y,x,z; 3 gives y,z,x; 4 gives z,x,y; 5 gives z,y,x.
- R3: While valid, the index is the offset (bits 21..18) plus x + y*X + z*X*Y, where X and Y are the x and y sizes. The permutation does not change this formula.
- R4: When the modulus field (bits 31..25) is non-zero, the index from R3 is reduced modulo that value and stays below it. A modulus of zero applies no reduction.
- R5: A shape word of all zeros disables remapping, and the index then equals the plain element number.
- R6: When X*Y*Z is smaller than VL, the counters return to zero after the last position and keep going, so earlier indices repeat.
- R7: A `start` with a resume element number k puts the block in the same state it would reach after k steps from element 0. The index for element k is presented in the cycle after `start`.
- R8: A permutation code of 6 or 7 captured at `start` raises `err`, and `valid` then stays low until the next `start`.
- R9: Each `step` while valid advances by exactly one element in one cycle. Once the element number equals VL, `valid` is low, and further `step` pulses leave `idx_out` unchanged.
- R10: After reset, `valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shape | input | 32 | Shape word, captured on start |
| cfg_vl | input | 7 | Vector length, captured on start |
| start | input | 1 | Load configuration and resume element |
| resume_idx | input | 7 | Element number to resume from |
| step | input | 1 | Advance to the next element |
| idx_out | output | 20 | Remapped element index |
| valid | output | 1 | idx_out belongs to a live element |
| err | output | 1 | Illegal permutation code was captured |

## Verification
The bench compares every element against a reference that runs nested counters from zero, so a design that swaps dimensions in one permutation, or uses the wrong stride, produces a wrong index at the first carry. Resume tests start partway into a sequence whose product is shorter than VL. A design that does not rebuild the counters from the resume number, or that ignores the wrap, starts on the wrong element. Offset with modulus, the all-zero bypass, illegal codes, and steps after VL are each tested. A design that wraps when the modulus is zero, or that keeps counting past VL, shows a mismatch at those points.

// File: rtl/elem_remap.sv
module elem_remap #(
  parameter int EW = 7,
  parameter int DW = 6,
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_shape,
  input  logic [EW-1:0] cfg_vl,
  input  logic          start,
  input  logic [EW-1:0] resume_idx,
  input  logic          step,
  output logic [IW-1:0] idx_out,
  output logic          valid,
  output logic          err
);
  localparam int LW = DW + 1;

  logic [31:0]   shape_q, sh;
  logic [EW-1:0] elem, vl_q;
  logic          run, err_q;
  logic [LW-1:0] cnt [4];
  logic [LW-1:0] nxt [4];
  logic [LW-1:0] lim [4];
  logic [LW-1:0] ld  [4];
  logic [1:0]    of, om, os;
  logic [IW-1:0] prod, pos, quo, xs, ys, lin;
  logic [6:0]    modv;

  assign sh = start ? cfg_shape : shape_q;

  always_comb begin
    lim[0] = LW'(sh[5:0]) + 1'b1;
    lim[1] = LW'(sh[11:6]) + 1'b1;
    lim[2] = LW'(sh[17:12]) + 1'b1;
    lim[3] = LW'(1);
    case (sh[24:22])
      3'd1:    begin of = 2'd0; om = 2'd2; os = 2'd1; end
      3'd2:    begin of = 2'd1; om = 2'd0; os = 2'd2; end
      3'd3:    begin of = 2'd1; om = 2'd2; os = 2'd0; end
      3'd4:    begin of = 2'd2; om = 2'd0; os = 2'd1; end
      3'd5:    begin of = 2'd2; om = 2'd1; os = 2'd0; end
      default: begin of = 2'd0; om = 2'd1; os = 2'd2; end
    endcase
  end

  always_comb begin
    prod = IW'(lim[of]) * IW'(lim[om]) * IW'(lim[os]);
    pos  = IW'(resume_idx) % prod;
    quo  = pos / IW'(lim[of]);
    for (int i = 0; i < 4; i++) ld[i] = '0;
    ld[of] = LW'(pos % IW'(lim[of]));
    ld[om] = LW'(quo % IW'(lim[om]));
    ld[os] = LW'(quo / IW'(lim[om]));
  end

  always_comb begin
    for (int i = 0; i < 4; i++) nxt[i] = cnt[i];
    nxt[of] = cnt[of] + 1'b1;
    if (nxt[of] == lim[of]) begin
      nxt[of] = '0;
      nxt[om] = cnt[om] + 1'b1;
      if (nxt[om] == lim[om]) begin
        nxt[om] = '0;
        nxt[os] = cnt[os] + 1'b1;
        if (nxt[os] == lim[os]) nxt[os] = '0;
      end
    end
  end

  assign valid = run & ~err_q & (elem < vl_q);
  assign err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q <= '0;
      elem    <= '0;
      vl_q    <= '0;
      run     <= 1'b0;
      err_q   <= 1'b0;
      for (int i = 0; i < 4; i++) cnt[i] <= '0;
    end else if (start) begin
      shape_q <= cfg_shape;
      vl_q    <= cfg_vl;
      elem    <= resume_idx;
      run     <= 1'b1;
      err_q   <= (cfg_shape[24:22] > 3'd5);
      for (int i = 0; i < 4; i++) cnt[i] <= ld[i];
    end else if (step && valid) begin
      elem <= elem + 1'b1;
      for (int i = 0; i < 4; i++) cnt[i] <= nxt[i];
    end
  end

  assign xs   = IW'(shape_q[5:0]) + 1'b1;
  assign ys   = IW'(shape_q[11:6]) + 1'b1;
  assign modv = shape_q[31:25];
  assign lin  = IW'(shape_q[21:18]) + IW'(cnt[0]) + IW'(cnt[1]) * xs
              + IW'(cnt[2]) * xs * ys;

  always_comb begin
    if (shape_q == '0)      idx_out = IW'(elem);
    else if (modv == '0)    idx_out = lin;
    else                    idx_out = lin % IW'(modv);
  end
endmodule

// File: rtl/elem_remap_chk.sv
module elem_remap_chk #(
  parameter int EW = 7,
  parameter int IW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          step,
  input logic          valid,
  input logic          err,
  input logic [IW-1:0] idx_out,
  input logic [31:0]   shape_q,
  input logic [EW-1:0] elem
);
  p_err_blocks_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid);

  p_mod_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && shape_q[31:25] != 7'd0) |-> (idx_out < IW'(shape_q[31:25])));

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && shape_q == 32'd0) |-> (idx_out == IW'(elem)));

  p_one_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && step && !start) |=> (elem == $past(elem) + 1'b1));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !start) |=> (!valid && $stable(idx_out)));
endmodule

bind elem_remap elem_remap_chk #(.EW(EW), .IW(IW)) chk (.*);

// File: tb/elem_remap_test.sv
module elem_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_shape = '0;
  logic [6:0]  cfg_vl = '0;
  logic        start = 1'b0;
  logic [6:0]  resume_idx = '0;
  logic        step = 1'b0;
  logic [19:0] idx_out;
  logic        valid, err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  elem_remap uut (.*);

  function automatic logic [31:0] mk(int x, int y, int z, int o, int p, int m);
    return {7'(m), 3'(p), 4'(o), 6'(z), 6'(y), 6'(x)};
  endfunction

  function automatic int ref_idx(logic [31:0] s, int n);
    int lim[3], c[3], ord[3], v;
    lim[0] = int'(s[5:0]) + 1; lim[1] = int'(s[11:6]) + 1; lim[2] = int'(s[17:12]) + 1;
    case (s[24:22])
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      3'd5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    c = '{0, 0, 0};
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 3; i++) begin
        c[ord[i]]++;
        if (c[ord[i]] != lim[ord[i]]) break;
        c[ord[i]] = 0;
      end
    end
    if (s == 32'd0) return n;
    v = int'(s[21:18]) + c[0] + c[1] * lim[0] + c[2] * lim[0] * lim[1];
    if (s[31:25] != 7'd0) v = v % int'(s[31:25]);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(logic [31:0] s, int vl, int res);
    @(negedge clk);
    cfg_shape = s; cfg_vl = 7'(vl); resume_idx = 7'(res); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_step;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic run_seq(logic [31:0] s, int vl, int res, string req);
    int last;
    do_start(s, vl, res);
    for (int n = res; n < vl; n++) begin
      check({req, " valid"}, int'(valid), 1);
      check({req, " index"}, int'(idx_out), ref_idx(s, n));
      do_step();
    end
    check({req, " R9 end valid"}, int'(valid), 0);
    last = int'(idx_out);
    do_step();
    do_step();
    check({req, " R9 hold"}, int'(idx_out), last);
    check({req, " R9 still idle"}, int'(valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 valid", int'(valid), 0);
    check("R10 err", int'(err), 0);
  endtask

  task automatic t_bypass;
    run_seq(32'd0, 12, 0, "R5 bypass");
  endtask

  task automatic t_dims;
    run_seq(mk(2, 3, 4, 0, 0, 0), 60, 0, "R1 R3 xyz");
  endtask

  task automatic t_perms;
    for (int p = 0; p < 6; p++) run_seq(mk(2, 3, 1, 0, p, 0), 24, 0, "R2 perm");
  endtask

  task automatic t_offs_mod;
    run_seq(mk(3, 2, 1, 5, 2, 7), 24, 0, "R4 mod7");
    run_seq(mk(3, 2, 1, 9, 3, 0), 24, 0, "R4 nowrap");
  endtask

  task automatic t_wrap;
    run_seq(mk(1, 2, 0, 1, 1, 0), 20, 0, "R6 wrap");
  endtask

  task automatic t_resume;
    run_seq(mk(2, 1, 2, 3, 4, 0), 40, 13, "R7 resume");
    run_seq(mk(1, 1, 1, 0, 5, 0), 30, 19, "R7 resume wrap");
  endtask

  task automatic t_illegal;
    do_start(mk(1, 1, 1, 0, 6, 0), 8, 0);
    check("R8 err p6", int'(err), 1);
    check("R8 valid p6", int'(valid), 0);
    do_step();
    check("R8 valid after step", int'(valid), 0);
    do_start(mk(1, 1, 1, 0, 7, 0), 8, 0);
    check("R8 err p7", int'(err), 1);
    do_start(mk(1, 1, 1, 0, 0, 0), 4, 0);
    check("R8 err cleared", int'(err), 0);
    check("R8 valid restored", int'(valid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_dims();
    t_perms();
    t_offs_mod();
    t_wrap();
    t_resume();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule